// File: doc/BRIEF.md
# Four-Link Byte Port Host Register Front-End

This block sits between a processor's memory-mapped bus and four byte-wide point-to-point links. It presents an eight-word register window: one data register per link, a read-only status word, a write-only event-mode register, an acknowledge strobe location and a clear location. The processor reads assembled words and writes words for transmission through this window. The links themselves hand bytes across with a strobe per byte.

On the receive side, each link's byte strobe is watched for rising edges. Bytes are packed into a 32-bit word, least-significant byte first. When the fourth byte lands, the word is latched and the link is flagged as holding data. On the transmit side, a written word is presented one byte at a time, and each rising edge of the peer's take strobe advances to the next byte. The buffer is flagged empty again after the fourth take. Each direction of each link emits a one-cycle word event. The event is either early, at the second byte, or late, at the fourth byte, as selected by a per-link, per-direction mode bit.

The data registers do not map to the links in order. Offsets 0x00, 0x04, 0x08 and 0x0C serve links 0, 3, 1 and 4. On the link side the byte lanes are ordered 0, 1, 3, 4.

Top module: `cport_host_regs`

## Requirements
- R1: After reset, the status word reads 0xAA (every transmit buffer empty, no receive data). All event outputs, `ack_o` and `tx_byte` are zero.
- R2: Data offsets 0x00/0x04/0x08/0x0C (slots 0..3) serve links 0/3/1/4. Link-side lanes 0..3 are links 0/1/3/4, so slot k uses lane {k[0],k[1]}. Each lane's byte sits at bits [8*lane+7:8*lane] of `rx_byte`/`tx_byte`.
- R3: Status word at offset 0x10: bit 2k is receive-data-available for slot k and bit 2k+1 is transmit-empty for slot k. Bits above 7 read zero.
- R4: Received bytes fill the word least-significant byte first. The word becomes readable, and its available bit sets, one cycle after the rising edge of the fourth byte strobe.
- R5: A host read of a data register clears that slot's available bit. If the fourth byte of the next word completes in the same cycle, the bit stays set and the new word replaces the old one. The read itself returns the old word.
- R6: A write to a data register loads the word and clears transmit-empty. `tx_byte` shows byte 0 first and advances on each take-strobe rising edge. Transmit-empty sets after the fourth take. Take strobes while empty are ignored.
- R7: The mode register at offset 0x14 holds one bit per slot and direction: bit 2k selects fast receive events for slot k and bit 2k+1 selects fast transmit events. When the bit is 0, a single one-cycle event follows the fourth byte edge. When it is 1, the event follows the second byte edge. There is exactly one event per word.
- R8: A strobe held high for several cycles counts as one byte.
- R9: `ack_o` is high in exactly those cycles where `bus_sel` is high with offset 0x18, for a read or a write.
- R10: A write to offset 0x1C drops all partial bytes, clears every available bit and sets every transmit-empty bit. It overrides a byte strobe in the same cycle. The mode register is kept.
- R11: Reads of offsets 0x14, 0x18 and 0x1C return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_sel | input | 1 | Host access in this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 5 | Byte offset in the window (low two bits ignored) |
| bus_wdata | input | 32 | Host write data |
| bus_rdata | output | 32 | Host read data, same cycle |
| ack_o | output | 1 | Acknowledge pulse |
| rx_strb | input | 4 | Per-lane receive byte strobe |
| rx_byte | input | 32 | Per-lane receive byte |
| rx_evt | output | 4 | Per-lane receive word event |
| tx_strb | input | 4 | Per-lane transmit take strobe |
| tx_byte | output | 32 | Per-lane byte being offered |
| tx_evt | output | 4 | Per-lane transmit word event |

## Verification
Two situations can fall in the same cycle.

The first is a host read that clears a slot's available bit together with the rising edge of the fourth byte of the next word on that link. The bench assembles one word, sends three bytes of a second word, then drives the data-register read and the last strobe in the same cycle. It judges the result by the old word on the read, a still-set status bit, and the new word on a second read.

The second is a write to the clear location landing on a byte strobe. The bench checks that only the four bytes sent afterwards form the next word.

// File: rtl/cport_pkg.sv
// Shared constants, decode bundle and slot-to-lane mapping for the
// four-link host register front-end. Assumes exactly four links.
package cport_pkg;

    localparam int unsigned LANES      = 4;
    localparam int unsigned IDX_STATUS = 4;
    localparam int unsigned IDX_MODE   = 5;
    localparam int unsigned IDX_ACK    = 6;
    localparam int unsigned IDX_CLEAR  = 7;

    // Decoded one-cycle access strobes for the current bus beat.
    typedef struct packed {
        logic [LANES-1:0] data_rd;
        logic [LANES-1:0] data_wr;
        logic             stat_rd;
        logic             mode_wr;
        logic             ack;
        logic             clear;
    } dec_t;

    // Register slot k serves link-side lane {k[0],k[1]} (bit-swapped index).
    function automatic int unsigned slot_lane(int unsigned slot);
        return ((slot & 1) << 1) | ((slot >> 1) & 1);
    endfunction

endpackage

// File: rtl/cport_decode.sv
// Address decoder for the eight-word register window.
// Assumes a word index (byte offset >> 2) and one-cycle bus beats.
module cport_decode
    import cport_pkg::*;
#(
    parameter int unsigned IW = 3
) (
    input  logic          sel_i,
    input  logic          wr_i,
    input  logic [IW-1:0] idx_i,
    output dec_t          dec_o
);

    // Turn the beat into at most one access strobe.
    always_comb begin
        dec_o = '0;
        if (sel_i) begin
            for (int k = 0; k < LANES; k++) begin
                if (idx_i == IW'(k)) begin
                    dec_o.data_rd[k] = !wr_i;
                    dec_o.data_wr[k] = wr_i;
                end
            end
            dec_o.stat_rd = !wr_i && (idx_i == IW'(IDX_STATUS));
            dec_o.mode_wr = wr_i  && (idx_i == IW'(IDX_MODE));
            dec_o.ack     = (idx_i == IW'(IDX_ACK));
            dec_o.clear   = wr_i  && (idx_i == IW'(IDX_CLEAR));
        end
    end

endmodule

// File: rtl/cport_rx_lane.sv
// Receive lane: packs strobed bytes LSB first into a word, flags it as
// available and emits one word event (early or late).
// Assumes the strobe is synchronous to clk; a byte is taken on its rising edge.
module cport_rx_lane #(
    parameter int unsigned BYTE_W = 8,
    parameter int unsigned BPW    = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                clr_i,
    input  logic                fast_i,
    input  logic                strb_i,
    input  logic [BYTE_W-1:0]   byte_i,
    input  logic                take_i,
    output logic [BPW*BYTE_W-1:0] word_o,
    output logic                avail_o,
    output logic                evt_o
);

    localparam int unsigned CW = $clog2(BPW);

    logic                        strb_q;
    logic [CW-1:0]               cnt_q;
    logic [BPW-1:0][BYTE_W-1:0]  asm_q;
    logic [BPW-1:0][BYTE_W-1:0]  asm_nxt;
    logic [BPW*BYTE_W-1:0]       word_q;
    logic                        avail_q;
    logic                        evt_q;
    logic                        rise;
    logic                        is_last;
    logic                        hit;

    assign rise    = strb_i && !strb_q;
    assign is_last = (cnt_q == CW'(BPW-1));
    assign hit     = fast_i ? (cnt_q == CW'(1)) : is_last;

    // Place the incoming byte at the current position.
    always_comb begin
        asm_nxt         = asm_q;
        asm_nxt[cnt_q]  = byte_i;
    end

    // Remember the previous strobe level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) strb_q <= 1'b0;
        else        strb_q <= strb_i;
    end

    // Byte counter and partial-word storage.
    always_ff @(posedge clk) begin
        if (!rst_n || clr_i) begin
            cnt_q <= '0;
            asm_q <= '0;
        end else if (rise) begin
            asm_q <= asm_nxt;
            cnt_q <= is_last ? '0 : cnt_q + CW'(1);
        end
    end

    // Completed word and its available flag; completion beats a host read.
    always_ff @(posedge clk) begin
        if (!rst_n || clr_i) begin
            word_q  <= '0;
            avail_q <= 1'b0;
        end else if (rise && is_last) begin
            word_q  <= asm_nxt;
            avail_q <= 1'b1;
        end else if (take_i) begin
            avail_q <= 1'b0;
        end
    end

    // One-cycle word event at the selected byte.
    always_ff @(posedge clk) begin
        if (!rst_n || clr_i) evt_q <= 1'b0;
        else                 evt_q <= rise && hit;
    end

    assign word_o  = word_q;
    assign avail_o = avail_q;
    assign evt_o   = evt_q;

    assert_evt_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
        evt_o |=> !evt_o);

    assert_word_on_last_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(avail_o) |-> ($past(cnt_q) == CW'(BPW-1)));

endmodule

// File: rtl/cport_tx_lane.sv
// Transmit lane: holds a host word, offers it byte by byte LSB first,
// advances on the peer's take strobe and emits one word event.
// Assumes the take strobe is synchronous to clk.
module cport_tx_lane #(
    parameter int unsigned BYTE_W = 8,
    parameter int unsigned BPW    = 4
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  clr_i,
    input  logic                  fast_i,
    input  logic                  strb_i,
    input  logic                  load_i,
    input  logic [BPW*BYTE_W-1:0] word_i,
    output logic [BYTE_W-1:0]     byte_o,
    output logic                  empty_o,
    output logic                  evt_o
);

    localparam int unsigned CW = $clog2(BPW);

    logic                       strb_q;
    logic [CW-1:0]              cnt_q;
    logic [BPW-1:0][BYTE_W-1:0] word_q;
    logic                       empty_q;
    logic                       evt_q;
    logic                       rise;
    logic                       is_last;
    logic                       hit;
    logic                       step;

    assign rise    = strb_i && !strb_q;
    assign is_last = (cnt_q == CW'(BPW-1));
    assign hit     = fast_i ? (cnt_q == CW'(1)) : is_last;
    assign step    = rise && !empty_q && !load_i;

    // Remember the previous strobe level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) strb_q <= 1'b0;
        else        strb_q <= strb_i;
    end

    // Capture the host word.
    always_ff @(posedge clk) begin
        if (!rst_n)      word_q <= '0;
        else if (load_i) word_q <= word_i;
    end

    // Byte position and empty flag.
    always_ff @(posedge clk) begin
        if (!rst_n || clr_i) begin
            cnt_q   <= '0;
            empty_q <= 1'b1;
        end else if (load_i) begin
            cnt_q   <= '0;
            empty_q <= 1'b0;
        end else if (step) begin
            cnt_q   <= is_last ? '0 : cnt_q + CW'(1);
            empty_q <= is_last;
        end
    end

    // One-cycle word event at the selected byte.
    always_ff @(posedge clk) begin
        if (!rst_n || clr_i) evt_q <= 1'b0;
        else                 evt_q <= step && hit;
    end

    assign byte_o  = word_q[cnt_q];
    assign empty_o = empty_q;
    assign evt_o   = evt_q;

    assert_idle_position_R6: assert property (@(posedge clk) disable iff (!rst_n)
        empty_o |-> (cnt_q == '0));

    assert_evt_when_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
        evt_o |-> !$past(empty_q));

endmodule

// File: rtl/cport_host_regs.sv
// Host register front-end for four byte-wide links: decodes the register
// window, keeps the event-mode bits, builds the status word and muxes read
// data. Assumes single-cycle bus beats with read data taken in the same cycle.
module cport_host_regs
    import cport_pkg::*;
#(
    parameter int unsigned BYTE_W = 8,
    parameter int unsigned BPW    = 4,
    parameter int unsigned OFS_W  = 5
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       bus_sel,
    input  logic                       bus_wr,
    input  logic [OFS_W-1:0]           bus_addr,
    input  logic [BPW*BYTE_W-1:0]      bus_wdata,
    output logic [BPW*BYTE_W-1:0]      bus_rdata,
    output logic                       ack_o,
    input  logic [LANES-1:0]           rx_strb,
    input  logic [LANES*BYTE_W-1:0]    rx_byte,
    output logic [LANES-1:0]           rx_evt,
    input  logic [LANES-1:0]           tx_strb,
    output logic [LANES*BYTE_W-1:0]    tx_byte,
    output logic [LANES-1:0]           tx_evt
);

    localparam int unsigned WORD_W = BPW * BYTE_W;
    localparam int unsigned IW     = OFS_W - 2;
    localparam int unsigned STAT_W = 2 * LANES;

    dec_t               dec;
    logic [STAT_W-1:0]  mode_q;
    logic [STAT_W-1:0]  status;
    logic [WORD_W-1:0]  rx_word_s [LANES];
    logic [LANES-1:0]   rx_avail_s;
    logic [LANES-1:0]   tx_empty_s;
    logic               unused_low_addr;

    assign unused_low_addr = ^bus_addr[1:0];

    cport_decode #(.IW(IW)) u_decode (
        .sel_i (bus_sel),
        .wr_i  (bus_wr),
        .idx_i (bus_addr[OFS_W-1:2]),
        .dec_o (dec)
    );

    // Event-mode bits, kept across a register-window clear.
    always_ff @(posedge clk) begin
        if (!rst_n)           mode_q <= '0;
        else if (dec.mode_wr) mode_q <= bus_wdata[STAT_W-1:0];
    end

    for (genvar s = 0; s < LANES; s++) begin : g_slot
        localparam int unsigned LN = slot_lane(s);

        cport_rx_lane #(.BYTE_W(BYTE_W), .BPW(BPW)) u_rx (
            .clk     (clk),
            .rst_n   (rst_n),
            .clr_i   (dec.clear),
            .fast_i  (mode_q[2*s]),
            .strb_i  (rx_strb[LN]),
            .byte_i  (rx_byte[LN*BYTE_W +: BYTE_W]),
            .take_i  (dec.data_rd[s]),
            .word_o  (rx_word_s[s]),
            .avail_o (rx_avail_s[s]),
            .evt_o   (rx_evt[LN])
        );

        cport_tx_lane #(.BYTE_W(BYTE_W), .BPW(BPW)) u_tx (
            .clk     (clk),
            .rst_n   (rst_n),
            .clr_i   (dec.clear),
            .fast_i  (mode_q[2*s+1]),
            .strb_i  (tx_strb[LN]),
            .load_i  (dec.data_wr[s]),
            .word_i  (bus_wdata),
            .byte_o  (tx_byte[LN*BYTE_W +: BYTE_W]),
            .empty_o (tx_empty_s[s]),
            .evt_o   (tx_evt[LN])
        );

        assign status[2*s]   = rx_avail_s[s];
        assign status[2*s+1] = tx_empty_s[s];
    end

    // Read data: a slot's word, the status word, or zero.
    always_comb begin
        bus_rdata = '0;
        for (int k = 0; k < LANES; k++) begin
            if (dec.data_rd[k]) bus_rdata = rx_word_s[k];
        end
        if (dec.stat_rd) bus_rdata[STAT_W-1:0] = status;
    end

    assign ack_o = dec.ack;

    assert_single_access_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({dec.data_rd, dec.data_wr, dec.stat_rd, dec.mode_wr, dec.ack, dec.clear}));

    assert_ack_window_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ack_o |-> (bus_sel && (bus_addr[OFS_W-1:2] == IW'(IDX_ACK))));

    assert_clear_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
        dec.clear |=> (status == {LANES{2'b10}}));

endmodule

// File: tb/cport_host_regs_tb.sv
// Self-checking bench: a vector table of bus accesses, then directed tests.
module cport_host_regs_tb_top;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        bus_sel, bus_wr;
    logic [4:0]  bus_addr;
    logic [31:0] bus_wdata, bus_rdata;
    logic        ack_o;
    logic [3:0]  rx_strb, rx_evt, tx_strb, tx_evt;
    logic [31:0] rx_byte, tx_byte;

    int n_chk = 0;
    int n_err = 0;

    always #4 clk = ~clk;

    cport_host_regs dut_i (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .ack_o(ack_o), .rx_strb(rx_strb), .rx_byte(rx_byte), .rx_evt(rx_evt),
        .tx_strb(tx_strb), .tx_byte(tx_byte), .tx_evt(tx_evt)
    );

    // {write, offset, wdata, expected read}
    localparam logic [69:0] VEC [10] = '{
        {1'b0, 5'h10, 32'h0,        32'h0000_00AA}, // R1 R3 idle status
        {1'b0, 5'h14, 32'h0,        32'h0},         // R11
        {1'b0, 5'h1C, 32'h0,        32'h0},         // R11
        {1'b1, 5'h04, 32'h11223344, 32'h0},         // R6 load slot1
        {1'b0, 5'h10, 32'h0,        32'h0000_00A2}, // R3 slot1 tx busy
        {1'b1, 5'h1C, 32'h0,        32'h0},         // R10 clear
        {1'b0, 5'h10, 32'h0,        32'h0000_00AA}, // R10
        {1'b1, 5'h08, 32'hCAFEF00D, 32'h0},         // R6 load slot2
        {1'b0, 5'h10, 32'h0,        32'h0000_008A}, // R3 slot2 tx busy
        {1'b0, 5'h18, 32'h0,        32'h0}          // R11
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic bus_write(input logic [4:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [4:0] a, output logic [31:0] d, output logic ak);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        #1;
        d  = bus_rdata;
        ak = ack_o;
        @(negedge clk);
        bus_sel = 1'b0;
    endtask

    task automatic rx_send(input int ln, input logic [7:0] b, output logic e);
        @(negedge clk);
        rx_strb[ln] = 1'b1; rx_byte[ln*8 +: 8] = b;
        @(negedge clk);
        e = rx_evt[ln];
        rx_strb[ln] = 1'b0;
    endtask

    task automatic tx_take(input int ln, output logic e);
        @(negedge clk);
        tx_strb[ln] = 1'b1;
        @(negedge clk);
        e = tx_evt[ln];
        tx_strb[ln] = 1'b0;
    endtask

    task automatic rx_word(input int ln, input logic [31:0] w, output logic [3:0] ev);
        for (int i = 0; i < 4; i++) begin
            logic e;
            rx_send(ln, w[i*8 +: 8], e);
            ev[i] = e;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_err++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        logic [31:0] d;
        logic        ak, e;
        logic [3:0]  ev;
        rst_n = 1'b0; bus_sel = 1'b0; bus_wr = 1'b0; bus_addr = '0; bus_wdata = '0;
        rx_strb = '0; rx_byte = '0; tx_strb = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state at the ports
        chk("R1 rx_evt", {28'h0, rx_evt}, 32'h0);
        chk("R1 tx_evt", {28'h0, tx_evt}, 32'h0);
        chk("R1 ack_o", {31'h0, ack_o}, 32'h0);
        chk("R1 tx_byte", tx_byte, 32'h0);

        // vector table walk
        for (int i = 0; i < 10; i++) begin
            if (VEC[i][69]) bus_write(VEC[i][68:64], VEC[i][63:32]);
            else begin
                bus_read(VEC[i][68:64], d, ak);
                chk($sformatf("R1/R3/R10/R11 vector %0d", i), d, VEC[i][31:0]);
            end
        end
        // R2 slot2 word lands on lane 1 (link 1), byte 0 first
        chk("R2 slot2 lane1 byte", {24'h0, tx_byte[15:8]}, 32'h0D);
        bus_write(5'h1C, 32'h0);

        // R4 R2: slot1 receives on lane 2; slow events by default (R7)
        rx_word(2, 32'h11223344, ev);
        chk("R7 slow rx event", {28'h0, ev}, 32'h8);
        bus_read(5'h10, d, ak);
        chk("R4 slot1 available", d, 32'hAE);
        bus_read(5'h04, d, ak);
        chk("R4 R2 slot1 word", d, 32'h11223344);
        bus_read(5'h10, d, ak);
        chk("R5 read clears available", d, 32'hAA);

        // R7 fast receive event on slot1
        bus_write(5'h14, 32'h04);
        rx_word(2, 32'h55667788, ev);
        chk("R7 fast rx event", {28'h0, ev}, 32'h2);
        bus_read(5'h04, d, ak);
        bus_write(5'h14, 32'h0);

        // R8 held strobe counts once (slot2, lane 1)
        @(negedge clk); rx_strb[1] = 1'b1; rx_byte[15:8] = 8'h01;
        repeat (3) @(negedge clk); rx_strb[1] = 1'b0;
        rx_send(1, 8'h02, e);
        rx_send(1, 8'h03, e);
        bus_read(5'h10, d, ak);
        chk("R8 three edges not a word", {31'h0, d[4]}, 32'h0);
        rx_send(1, 8'h04, e);
        bus_read(5'h10, d, ak);
        chk("R8 fourth edge completes", {31'h0, d[4]}, 32'h1);
        bus_read(5'h08, d, ak);
        chk("R8 R4 word order", d, 32'h04030201);

        // R6 transmit on slot0 (lane 0), slow then fast (R7)
        bus_write(5'h00, 32'hA1B2C3D4);
        chk("R6 first byte", {24'h0, tx_byte[7:0]}, 32'hD4);
        tx_take(0, e); ev[0] = e;
        chk("R6 second byte", {24'h0, tx_byte[7:0]}, 32'hC3);
        tx_take(0, e); ev[1] = e;
        tx_take(0, e); ev[2] = e;
        chk("R6 fourth byte", {24'h0, tx_byte[7:0]}, 32'hA1);
        bus_read(5'h10, d, ak);
        chk("R6 busy before last take", {31'h0, d[1]}, 32'h0);
        tx_take(0, e); ev[3] = e;
        chk("R7 slow tx event", {28'h0, ev}, 32'h8);
        bus_read(5'h10, d, ak);
        chk("R6 empty after last take", {31'h0, d[1]}, 32'h1);
        tx_take(0, e);
        chk("R6 take while empty ignored", {31'h0, e}, 32'h0);
        bus_write(5'h14, 32'h02);
        bus_write(5'h00, 32'h01020304);
        for (int i = 0; i < 4; i++) begin tx_take(0, e); ev[i] = e; end
        chk("R7 fast tx event", {28'h0, ev}, 32'h2);
        bus_write(5'h14, 32'h0);

        // R5 collision: host read and fourth byte in one cycle (slot0, lane 0)
        rx_word(0, 32'h0D0C0B0A, ev);
        rx_send(0, 8'h1A, e); rx_send(0, 8'h1B, e); rx_send(0, 8'h1C, e);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = 5'h00;
        rx_strb[0] = 1'b1; rx_byte[7:0] = 8'h1D;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_sel = 1'b0; rx_strb[0] = 1'b0;
        chk("R5 collision read old word", d, 32'h0D0C0B0A);
        bus_read(5'h10, d, ak);
        chk("R5 available kept", {31'h0, d[0]}, 32'h1);
        bus_read(5'h00, d, ak);
        chk("R5 new word held", d, 32'h1D1C1B1A);

        // R10 collision: clear write with a strobe (slot3, lane 3)
        rx_send(3, 8'hEE, e); rx_send(3, 8'hEE, e);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = 5'h1C;
        rx_strb[3] = 1'b1; rx_byte[31:24] = 8'hEE;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0; rx_strb[3] = 1'b0;
        rx_send(3, 8'h55, e); rx_send(3, 8'h66, e); rx_send(3, 8'h77, e);
        bus_read(5'h10, d, ak);
        chk("R10 partial dropped", {31'h0, d[6]}, 32'h0);
        rx_send(3, 8'h88, e);
        bus_read(5'h10, d, ak);
        chk("R10 word after clear", {31'h0, d[6]}, 32'h1);
        bus_read(5'h0C, d, ak);
        chk("R10 R2 slot3 word", d, 32'h88776655);

        // R9 acknowledge pulse
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = 5'h18;
        #1 chk("R9 ack on write", {31'h0, ack_o}, 32'h1);
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
        #1 chk("R9 ack low when idle", {31'h0, ack_o}, 32'h0);
        bus_read(5'h18, d, ak);
        chk("R9 ack on read", {31'h0, ak}, 32'h1);
        chk("R11 ack read data", d, 32'h0);
        bus_read(5'h10, d, ak);
        chk("R9 no ack elsewhere", {31'h0, ak}, 32'h0);

        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule